// File: doc/BRIEF.md
# Two-Bank Frame Store with Consumer Ownership

This block sits between a pixel producer that streams samples of a linear sensor frame and a consumer that processes the newest finished frame. It holds two banks of pixel storage. The producer always writes into the bank selected for writing. The other bank keeps the last completed frame, together with the timestamp that frame was closed with.

A one-bit ownership flag governs the hand-off. On a frame-start pulse, if the consumer does not hold the stable bank, the banks trade roles and ownership passes to the consumer. If the consumer still holds the stable bank, the banks keep their roles and the producer simply refills its own bank. Only the consumer gives ownership back, with a one-cycle release pulse. While it holds ownership, the consumer reads pixels by address and sees the stable bank's timestamp.

Top module: `pingpong_frame_store`

## Requirements
- R1: After reset the write selector is bank 0, `ready` is low, `rd_data` is 0 and `rd_ts` is 0.
- R2: A `frame_start` pulse while `ready` is low swaps the banks. After that edge `ready` is high and the frame just written is the stable bank.
- R3: A `frame_start` pulse while `ready` is high and `cons_release` is low leaves the banks unchanged and `ready` high. Stable pixels and `rd_ts` keep their values while the producer keeps writing.
- R4: `cons_release` drops `ready` at the next edge. `ready` rises only at a `frame_start` edge and falls only at a release edge.
- R5: When `cons_release` and `frame_start` arrive in the same cycle, the release is applied first. The banks therefore swap and `ready` stays high.
- R6: A write strobe with `wr_idx` at or below 1545 stores `wr_pix` in the bank being written, never in the stable bank. Each bank has 1546 pixels of 8 bits, and its depth is rounded up to 1548 entries.
- R7: `rd_data` is registered. One edge after `rd_addr` is presented, it shows the stable bank's pixel at that address while `ready` is high. It shows 0 while `ready` is low or when `rd_addr` is above 1545.
- R8: Each `frame_start` stores `frame_ts` as the timestamp of the bank being written in that cycle. `rd_ts` always shows the timestamp of the bank not selected for writing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Producer pixel write strobe |
| wr_idx | input | 11 | Pixel index of the write |
| wr_pix | input | 8 | Pixel value to write |
| frame_start | input | 1 | One-cycle pulse that closes the current frame |
| frame_ts | input | 32 | Timestamp given to the frame being closed |
| cons_release | input | 1 | Consumer hands the stable bank back |
| rd_addr | input | 11 | Consumer read address |
| ready | output | 1 | Consumer holds the stable bank |
| rd_data | output | 8 | Stable bank pixel, one cycle after the address |
| rd_ts | output | 32 | Timestamp of the stable bank |

## Verification
A wrong selector shows up one edge after the swap. The consumer then reads the frame that the producer is still writing, so newly written pixels leak into `rd_data` and `rd_ts` shows the producer bank's time. A wrong ownership flag shows up at once on `ready`: the flag stays high after a release, or a held frame-start replaces the consumer's data. The directed tests close frames with distinct pixel patterns and timestamps. This lets every swap, hold and collision case be told apart from a single read one cycle later.

// File: rtl/pingpong_frame_store.sv
module pingpong_frame_store #(
  parameter int PIX_W = 8,
  parameter int NPIX  = 1546,
  parameter int TS_W  = 32,
  localparam int DEPTH = ((NPIX + 3) / 4) * 4,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [PIX_W-1:0] wr_pix,
  input  logic             frame_start,
  input  logic [TS_W-1:0]  frame_ts,
  input  logic             cons_release,
  input  logic [AW-1:0]    rd_addr,
  output logic             ready,
  output logic [PIX_W-1:0] rd_data,
  output logic [TS_W-1:0]  rd_ts
);

  localparam logic [AW-1:0] LAST = AW'(NPIX - 1);

  logic             sel;
  logic             owned;
  logic [TS_W-1:0]  ts0, ts1;
  logic [PIX_W-1:0] bank0 [DEPTH];
  logic [PIX_W-1:0] bank1 [DEPTH];

  wire held  = owned & ~cons_release;
  wire swap  = frame_start & ~held;
  wire wr_ok = wr_en & (wr_idx <= LAST);
  wire rd_ok = owned & (rd_addr <= LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel   <= 1'b0;
      owned <= 1'b0;
    end else if (swap) begin
      sel   <= ~sel;
      owned <= 1'b1;
    end else if (cons_release) begin
      owned <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts0 <= '0;
      ts1 <= '0;
    end else if (frame_start) begin
      if (sel) ts1 <= frame_ts;
      else     ts0 <= frame_ts;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      if (sel) bank1[wr_idx] <= wr_pix;
      else     bank0[wr_idx] <= wr_pix;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_ok) rd_data <= sel ? bank0[rd_addr] : bank1[rd_addr];
    else            rd_data <= '0;
  end

  assign ready = owned;
  assign rd_ts = sel ? ts0 : ts1;

endmodule

// File: rtl/ppfs_checker.sv
module ppfs_checker (
  input logic clk,
  input logic rst_n,
  input logic frame_start,
  input logic cons_release,
  input logic ready,
  input logic sel
);

  assert_swap_when_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !ready) |=> (ready && sel != $past(sel)));

  assert_hold_when_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && ready && !cons_release) |=> (ready && $stable(sel)));

  assert_release_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_release && !frame_start) |=> !ready);

  assert_rise_needs_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(frame_start));

  assert_fall_needs_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(cons_release));

  assert_release_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cons_release) |=> (ready && sel != $past(sel)));

  assert_sel_moves_on_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> $past(frame_start));

endmodule

bind pingpong_frame_store ppfs_checker u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .frame_start(frame_start),
  .cons_release(cons_release),
  .ready(ready),
  .sel(sel)
);

// File: tb/tb_pingpong_frame_store.sv
module tb_pingpong_frame_store;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [10:0] wr_idx = '0;
  logic [7:0]  wr_pix = '0;
  logic        frame_start = 1'b0;
  logic [31:0] frame_ts = '0;
  logic        cons_release = 1'b0;
  logic [10:0] rd_addr = '0;
  logic        ready;
  logic [7:0]  rd_data;
  logic [31:0] rd_ts;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  pingpong_frame_store dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_pix(wr_pix),
    .frame_start(frame_start), .frame_ts(frame_ts), .cons_release(cons_release),
    .rd_addr(rd_addr), .ready(ready), .rd_data(rd_data), .rd_ts(rd_ts)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_px(input int idx, input logic [7:0] val);
    wr_en = 1'b1; wr_idx = 11'(idx); wr_pix = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic fs, input logic rel, input logic [31:0] ts);
    frame_start = fs; cons_release = rel; frame_ts = ts;
    @(negedge clk);
    frame_start = 1'b0; cons_release = 1'b0;
  endtask

  task automatic read_px(input int addr, output logic [7:0] val);
    rd_addr = 11'(addr);
    @(negedge clk);
    val = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 ready", 32'(ready), 0);
    check("R1 rd_ts", rd_ts, 0);
    read_px(0, v);
    check("R1 rd_data", 32'(v), 0);
  endtask

  task automatic t_first_swap;
    logic [7:0] v;
    write_px(0, 8'hA0);
    write_px(1545, 8'hA5);
    pulse(1'b1, 1'b0, 32'd100);
    check("R2 ready after swap", 32'(ready), 1);
    check("R8 rd_ts after swap", rd_ts, 100);
    read_px(0, v);
    check("R7 pixel 0 of frame A", 32'(v), 32'hA0);
    read_px(1545, v);
    check("R7 last pixel of frame A", 32'(v), 32'hA5);
    read_px(1600, v);
    check("R7 address past frame", 32'(v), 0);
  endtask

  task automatic t_hold;
    logic [7:0] v;
    write_px(0, 8'h11);
    pulse(1'b1, 1'b0, 32'd200);
    check("R3 ready held", 32'(ready), 1);
    check("R3 rd_ts unchanged", rd_ts, 100);
    write_px(0, 8'h22);
    read_px(0, v);
    check("R6 producer write kept out of stable bank", 32'(v), 32'hA0);
  endtask

  task automatic t_release_and_swap;
    logic [7:0] v;
    pulse(1'b0, 1'b1, 32'd0);
    check("R4 ready drops on release", 32'(ready), 0);
    read_px(0, v);
    check("R7 read while not owned", 32'(v), 0);
    check("R4 ready stays low without frame", 32'(ready), 0);
    pulse(1'b1, 1'b0, 32'd300);
    check("R2 ready after second swap", 32'(ready), 1);
    check("R8 rd_ts of refilled bank", rd_ts, 300);
    read_px(0, v);
    check("R3 refilled bank holds last write", 32'(v), 32'h22);
  endtask

  task automatic t_same_cycle;
    logic [7:0] v;
    write_px(0, 8'h33);
    pulse(1'b1, 1'b1, 32'd400);
    check("R5 ready stays high", 32'(ready), 1);
    check("R5 rd_ts new frame", rd_ts, 400);
    read_px(0, v);
    check("R5 stable bank swapped", 32'(v), 32'h33);
    read_px(1545, v);
    check("R6 older pixel kept in bank 0", 32'(v), 32'hA5);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_swap();
    t_hold();
    t_release_and_swap();
    t_same_cycle();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule